// File: doc/BRIEF.md
# Button-Paced Serial Byte Sender

This block sends a fixed sequence of bytes on an asynchronous serial line, one byte for each push of a button. A constant table of 32 bytes is built into the block. The block produces its own read address, which starts at zero and moves forward one entry at a time. Pressing the active-low button copies the byte at the current address into a holding register, and the address then moves on. Releasing the button sends the held byte as one 8N1 frame at the configured baud rate.

The raw button passes through a synchronizer. Two flag registers then hold the present and previous pressed levels. Press and release are detected by comparing these flags, so no logic is clocked by the button itself. The held byte is visible on an output port so that it can be observed. A busy flag is high for exactly the length of one frame.

Top module: `rom_button_tx`

## Requirements
- R1: While reset is asserted and just after it is released, `tx` is high, `busy` is low and `cur_byte` is 0. The table address returns to 0, so the first press after reset loads entry 0.
- R2: A press (falling edge of `btn_n`) copies table entry i into `cur_byte`, where i is the current address. Entry i has the value `8'hA5 ^ ((i*7) mod 256)`.
- R3: The address goes up by one after every press. After entry 31 it wraps to entry 0, so press k after reset (counting from 0) loads entry `k mod 32`.
- R4: A release (rising edge of `btn_n`) while idle sends `cur_byte` as one frame. The frame is a low start bit, then 8 data bits with the least significant bit first, then a high stop bit.
- R5: Each bit lasts BIT_CYC = round(CLK_HZ/BAUD) clock cycles. `busy` stays high for exactly 10*BIT_CYC cycles per frame.
- R6: A release that arrives while `busy` is high is ignored. No frame follows the current one.
- R7: A press during a frame updates `cur_byte` and advances the address. The frame already being sent still carries its original byte.
- R8: The line idles high whenever `busy` is low. Holding the button pressed without releasing it sends nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously outside the block |
| btn_n | input | 1 | Raw button level, low while pressed |
| tx | output | 1 | Serial transmit line, idles high |
| busy | output | 1 | High while a frame is on the line |
| cur_byte | output | 8 | Byte most recently loaded from the table |

## Verification
The bench builds the block with CLK_HZ = 1000 and BAUD = 125. This gives a bit time of 8 cycles and a frame of 80 cycles, where the default settings give 434 and 4340. With frames this short, the bench can step through all 32 table entries and the wrap back to entry 0. It can also check every bit at its centre, place a press and release inside a running frame, and apply reset in the middle of a frame, all within a short run.

// File: rtl/rom_button_tx_pkg.sv
package rom_button_tx_pkg;

  typedef enum logic [1:0] {
    TX_IDLE  = 2'd0,
    TX_START = 2'd1,
    TX_DATA  = 2'd2,
    TX_STOP  = 2'd3
  } tx_state_e;

  // Constant table contents: entry idx = A5h xor (idx*7) mod 256
  function automatic logic [7:0] table_entry(input int unsigned idx);
    logic [7:0] mult;
    mult = 8'((idx * 7) & 255);
    return 8'hA5 ^ mult;
  endfunction

endpackage

// File: rtl/btn_edge.sv
module btn_edge #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic btn_n_i,
  output logic press_o,
  output logic release_o
);

  logic [SYNC_STAGES-1:0] sync_q, sync_d;
  logic                   cur_q, cur_d;
  logic                   prev_q, prev_d;

  // next-state
  always_comb begin
    sync_d = {sync_q[SYNC_STAGES-2:0], btn_n_i};
    cur_d  = ~sync_q[SYNC_STAGES-1];
    prev_d = cur_q;
  end

  // registers; synchronizer resets to the released level, flags to not-pressed
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '1;
      cur_q  <= 1'b0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= sync_d;
      cur_q  <= cur_d;
      prev_q <= prev_d;
    end
  end

  assign press_o   = cur_q & ~prev_q;
  assign release_o = ~cur_q & prev_q;

endmodule

// File: rtl/byte_rom.sv
module byte_rom #(
  parameter int DEPTH  = 32,
  parameter int DATA_W = 8,
  localparam int ADDR_W = $clog2(DEPTH)
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic [DATA_W-1:0] data_o
);

  logic [DATA_W-1:0] table_w [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_entry
    assign table_w[i] = DATA_W'(rom_button_tx_pkg::table_entry(i));
  end

  assign data_o = table_w[addr_i];

endmodule

// File: rtl/tx_serializer.sv
module tx_serializer #(
  parameter int DATA_W  = 8,
  parameter int BIT_CYC = 434,
  localparam int CNT_W  = (BIT_CYC > 1) ? $clog2(BIT_CYC) : 1,
  localparam int IDX_W  = (DATA_W > 1) ? $clog2(DATA_W) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              tx_o,
  output logic              busy_o
);
  import rom_button_tx_pkg::*;

  tx_state_e         st_q, st_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [IDX_W-1:0]  idx_q, idx_d;
  logic [DATA_W-1:0] sh_q, sh_d;
  logic              tx_q, tx_d;
  logic              bit_end;

  assign bit_end = (cnt_q == CNT_W'(BIT_CYC - 1));

  // next-state
  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    idx_d = idx_q;
    sh_d  = sh_q;
    tx_d  = tx_q;
    if (st_q != TX_IDLE) begin
      cnt_d = bit_end ? '0 : cnt_q + CNT_W'(1);
    end
    unique case (st_q)
      TX_IDLE: begin
        if (start_i) begin
          st_d  = TX_START;
          sh_d  = data_i;
          tx_d  = 1'b0;
          cnt_d = '0;
        end
      end
      TX_START: begin
        if (bit_end) begin
          st_d  = TX_DATA;
          idx_d = '0;
          tx_d  = sh_q[0];
        end
      end
      TX_DATA: begin
        if (bit_end) begin
          if (idx_q == IDX_W'(DATA_W - 1)) begin
            st_d = TX_STOP;
            tx_d = 1'b1;
          end else begin
            idx_d = idx_q + IDX_W'(1);
            sh_d  = sh_q >> 1;
            tx_d  = sh_q[1];
          end
        end
      end
      TX_STOP: begin
        if (bit_end) begin
          st_d = TX_IDLE;
          tx_d = 1'b1;
        end
      end
      default: st_d = TX_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= TX_IDLE;
      cnt_q <= '0;
      idx_q <= '0;
      sh_q  <= '0;
      tx_q  <= 1'b1;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
      idx_q <= idx_d;
      sh_q  <= sh_d;
      tx_q  <= tx_d;
    end
  end

  assign tx_o   = tx_q;
  assign busy_o = (st_q != TX_IDLE);

endmodule

// File: rtl/rom_button_tx.sv
module rom_button_tx #(
  parameter int CLK_HZ      = 50_000_000,
  parameter int BAUD        = 115_200,
  parameter int DEPTH       = 32,
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              btn_n,
  output logic              tx,
  output logic              busy,
  output logic [DATA_W-1:0] cur_byte
);

  localparam int ADDR_W  = $clog2(DEPTH);
  localparam int BIT_CYC = (CLK_HZ + BAUD / 2) / BAUD;

  logic              press_pulse;
  logic              release_pulse;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [DATA_W-1:0] byte_q, byte_d;
  logic [DATA_W-1:0] rom_q;
  logic              start_go;

  btn_edge #(
    .SYNC_STAGES(SYNC_STAGES)
  ) u_edge (
    .clk      (clk),
    .rst_n    (rst_n),
    .btn_n_i  (btn_n),
    .press_o  (press_pulse),
    .release_o(release_pulse)
  );

  byte_rom #(
    .DEPTH (DEPTH),
    .DATA_W(DATA_W)
  ) u_rom (
    .addr_i(addr_q),
    .data_o(rom_q)
  );

  // next-state: load and step on press (clock enable = press_pulse)
  always_comb begin
    addr_d = addr_q;
    byte_d = byte_q;
    if (press_pulse) begin
      byte_d = rom_q;
      addr_d = (addr_q == ADDR_W'(DEPTH - 1)) ? '0 : addr_q + ADDR_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      byte_q <= '0;
    end else begin
      addr_q <= addr_d;
      byte_q <= byte_d;
    end
  end

  // release while a frame is in flight is dropped
  assign start_go = release_pulse & ~busy;

  tx_serializer #(
    .DATA_W (DATA_W),
    .BIT_CYC(BIT_CYC)
  ) u_ser (
    .clk    (clk),
    .rst_n  (rst_n),
    .start_i(start_go),
    .data_i (byte_q),
    .tx_o   (tx),
    .busy_o (busy)
  );

  assign cur_byte = byte_q;

endmodule

// File: rtl/rom_button_tx_chk.sv
module rom_button_tx_chk #(
  parameter int DATA_W    = 8,
  parameter int ADDR_W    = 5,
  parameter int DEPTH     = 32,
  parameter int FRAME_CYC = 4340
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tx,
  input logic              busy,
  input logic [DATA_W-1:0] cur_byte,
  input logic              press,
  input logic [ADDR_W-1:0] addr,
  input logic [DATA_W-1:0] rom_q
);

  int unsigned run_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run_cnt <= 0;
    else if (busy) run_cnt <= run_cnt + 1;
    else run_cnt <= 0;
  end

  assert_load_entry_R2: assert property (@(posedge clk) disable iff (!rst_n)
    press |=> cur_byte == $past(rom_q));

  assert_addr_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    press |=> addr == (($past(addr) == ADDR_W'(DEPTH - 1)) ? '0 : $past(addr) + ADDR_W'(1)));

  assert_start_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> !tx);

  assert_frame_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> run_cnt < FRAME_CYC);

  assert_frame_len_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> run_cnt == FRAME_CYC);

  assert_idle_high_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> tx);

endmodule

bind rom_button_tx rom_button_tx_chk #(
  .DATA_W   (DATA_W),
  .ADDR_W   ($clog2(DEPTH)),
  .DEPTH    (DEPTH),
  .FRAME_CYC(10 * ((CLK_HZ + BAUD / 2) / BAUD))
) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .tx      (tx),
  .busy    (busy),
  .cur_byte(cur_byte),
  .press   (press_pulse),
  .addr    (addr_q),
  .rom_q   (rom_q)
);

// File: tb/tb_rom_button_tx.sv
`timescale 1ns/1ps
module tb_rom_button_tx;

  localparam int CLK_HZ = 1000;
  localparam int BAUD   = 125;
  localparam int BIT    = (CLK_HZ + BAUD / 2) / BAUD;  // 8
  localparam int FRAME  = 10 * BIT;                     // 80

  typedef struct packed {
    logic [7:0] hold;
    logic [7:0] gap;
  } vec_t;

  localparam int VEC_N = 6;
  localparam vec_t VEC [VEC_N] = '{
    '{hold: 8'd6,  gap: 8'd10},
    '{hold: 8'd9,  gap: 8'd3},
    '{hold: 8'd40, gap: 8'd1},
    '{hold: 8'd7,  gap: 8'd25},
    '{hold: 8'd15, gap: 8'd0},
    '{hold: 8'd6,  gap: 8'd60}
  };

  logic       clk = 1'b0;
  logic       rst_n;
  logic       btn_n;
  logic       tx;
  logic       busy;
  logic [7:0] cur_byte;

  int checks = 0;
  int fails  = 0;
  int naddr  = 0;
  int cycles = 0;

  always #4 clk = ~clk;

  rom_button_tx #(
    .CLK_HZ(CLK_HZ),
    .BAUD  (BAUD)
  ) dut (
    .clk     (clk),
    .rst_n   (rst_n),
    .btn_n   (btn_n),
    .tx      (tx),
    .busy    (busy),
    .cur_byte(cur_byte)
  );

  function automatic logic [7:0] exp_entry(input int i);
    int m;
    m = (i * 7) % 256;
    return 8'hA5 ^ m[7:0];
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  task automatic wait_cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // press the button, check the loaded byte (R2, R3)
  task automatic press(input int hold, input string req);
    btn_n = 1'b0;
    wait_cyc(6);
    check(cur_byte == exp_entry(naddr), req, "cur_byte after press",
          cur_byte, exp_entry(naddr));
    naddr = (naddr + 1) % 32;
    if (hold > 6) wait_cyc(hold - 6);
  endtask

  // release the button and decode one frame (R4, R5, optionally R6/R7)
  task automatic send_frame(input logic [7:0] exp, input bit inject, input string req);
    int n;
    int to;
    logic [9:0] got;
    btn_n = 1'b1;
    to = 0;
    while (!busy && to < 30) begin
      @(negedge clk);
      to++;
    end
    check(busy == 1'b1, "R4", "busy after release", busy, 1);
    n = 0;
    got = '0;
    while (busy && n < 3 * FRAME) begin
      if ((n % BIT) == BIT / 2 && n < FRAME) got[n / BIT] = tx;
      if (inject && n == 2 * BIT) btn_n = 1'b0;
      if (inject && n == 4 * BIT) btn_n = 1'b1;
      @(negedge clk);
      n++;
    end
    check(n == FRAME, "R5", "busy length", n, FRAME);
    check(got[0] == 1'b0 && got[9] == 1'b1, "R4", "start/stop bits",
          {got[9], got[0]}, 2'b10);
    check(got[8:1] == exp, req, "frame data", got[8:1], exp);
  endtask

  initial begin
    while (cycles < 150000) begin
      @(posedge clk);
      cycles++;
    end
    fails++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    rst_n = 1'b0;
    btn_n = 1'b1;
    wait_cyc(3);
    // R1: reset state
    check(tx == 1'b1, "R1", "tx in reset", tx, 1);
    check(busy == 1'b0, "R1", "busy in reset", busy, 0);
    check(cur_byte == 8'h00, "R1", "cur_byte in reset", cur_byte, 0);
    rst_n = 1'b1;
    wait_cyc(2);
    check(tx == 1'b1 && busy == 1'b0, "R1", "idle after reset", {tx, busy}, 2'b10);

    // vector loop: presses with varied hold and gap, each sending a frame
    for (int v = 0; v < VEC_N; v++) begin
      logic [7:0] e;
      e = exp_entry(naddr);
      press(int'(VEC[v].hold), "R2");
      send_frame(e, 1'b0, "R4");
      wait_cyc(int'(VEC[v].gap));
    end

    // R7 / R6: press and release inside a running frame
    begin
      logic [7:0] e0;
      logic [7:0] e1;
      bit seen;
      e0 = exp_entry(naddr);
      e1 = exp_entry((naddr + 1) % 32);
      press(8, "R2");
      send_frame(e0, 1'b1, "R7");
      naddr = (naddr + 1) % 32;
      check(cur_byte == e1, "R7", "cur_byte loaded during frame", cur_byte, e1);
      seen = 1'b0;
      for (int i = 0; i < 2 * FRAME; i++) begin
        @(negedge clk);
        if (busy || !tx) seen = 1'b1;
      end
      check(!seen, "R6", "no frame after ignored release", seen, 0);
    end

    // R8: holding the button sends nothing
    begin
      bit seen;
      logic [7:0] e;
      e = exp_entry(naddr);
      btn_n = 1'b0;
      seen = 1'b0;
      for (int i = 0; i < 200; i++) begin
        @(negedge clk);
        if (busy || !tx) seen = 1'b1;
      end
      check(!seen, "R8", "line quiet while held", seen, 0);
      check(cur_byte == e, "R2", "cur_byte while held", cur_byte, e);
      naddr = (naddr + 1) % 32;
      send_frame(e, 1'b0, "R8");
      wait_cyc(4);
    end

    // R3: step through the rest of the table and past the wrap
    while (naddr != 0) begin
      logic [7:0] e;
      e = exp_entry(naddr);
      press(6, "R3");
      send_frame(e, 1'b0, "R3");
    end
    press(6, "R3");  // entry 0 again after wrap
    send_frame(exp_entry(0), 1'b0, "R3");
    press(6, "R3");  // entry 1
    send_frame(exp_entry(1), 1'b0, "R3");

    // R1: reset in the middle of a frame
    btn_n = 1'b0;
    wait_cyc(6);
    btn_n = 1'b1;
    wait_cyc(30);
    check(busy == 1'b1, "R1", "busy before mid-frame reset", busy, 1);
    rst_n = 1'b0;
    #1;
    check(tx == 1'b1 && busy == 1'b0, "R1", "line after mid-frame reset", {tx, busy}, 2'b10);
    check(cur_byte == 8'h00, "R1", "cur_byte after mid-frame reset", cur_byte, 0);
    wait_cyc(2);
    rst_n = 1'b1;
    naddr = 0;
    wait_cyc(3);
    press(6, "R1");
    send_frame(exp_entry(0), 1'b0, "R1");

    summary();
  end

endmodule